// File: doc/BRIEF.md
# Synthesizer Tuning Register Slave

This block is a standard-mode I2C target that sits in front of a frequency-synthesizer core. It watches the serial clock and data lines using the system clock. It answers one 7-bit address. The top five address bits are a fixed prefix and the bottom two come from a strapping input, so four parts can share one bus. During a write it sorts the incoming data bytes into three groups: a 15-bit divider word, a control byte and a band/port byte. Each group goes into its own shadow register and is handed to the synthesizer outputs only when the group is complete. During a read it returns a single status byte that holds a power-on flag, the lock flag and three comparator levels.

The first bit of every group-opening byte selects the group. A 0 opens a two-byte divider pair. A 1 opens a control byte, which is always followed by a band byte. Any number of groups may follow one address, so a host can sweep frequency by streaming divider pairs. A stop or a repeated start throws away a half-received divider pair and keeps everything already committed. SDA is modelled as the sampled line plus an active-high pull-down enable.

Top module: `synth_i2c_ctrl`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1,1,0,0,0,hw_addr_i[1],hw_addr_i[0]. After any other address it never pulls SDA low and ignores the data bytes that follow.
- R2: The last address bit selects the direction: 0 means the master writes data bytes and 1 means the block returns status bytes.
- R3: In a write, the block pulls SDA low during the ninth clock of every data byte.
- R4: A data byte whose MSB is 0, received when no group is open, holds the upper seven divider bits in its bits 6..0. The next byte holds divider bits 7..0. divider_o changes only after that second byte has arrived.
- R5: A byte whose MSB is 1, received when no group is open (right after the address or after a finished group), is a control byte. Its bit 6 drives cp_hi_o, bit 5 test_en_o, bit 4 pump_off_o, bits 3..2 test_sel_o[1:0], bit 1 ref_div64_o and bit 0 tune_off_o.
- R6: The byte directly after a control byte is the band byte, whatever its MSB. Its bit 7 drives port_o[2], bit 6 if_sel_o, bit 5 port_o[1], bit 4 port_o[0] and bit 0 band_o. Bits 3..1 are ignored.
- R7: Several groups can be written one after another in one transaction without repeating the address. Each group takes effect when it completes.
- R8: A stop or repeated start that arrives after only the first byte of a divider pair discards that byte. The next byte then opens a new group, and values committed earlier stay unchanged.
- R9: The status byte, sent MSB first, is {POR, lock_i, cmp_i[2], cmp_i[1], cmp_i[0], 1, 1, 1}.
- R10: POR is 1 after reset and after any cycle with supply_fail_i high. It goes to 0 once a status byte has been clocked out to the master.
- R11: After reset, divider_o is 0, ref_div64_o and tune_off_o are 1, and every other register output and sda_oe are 0.
- R12: In a read, a master ACK makes the block send another status byte. A master NACK makes it release SDA until the next start condition. A stop always releases SDA.
- R13: sda_oe changes only in response to a falling SCL edge, a start condition or a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| hw_addr_i | input | 2 | Strapped low address bits |
| lock_i | input | 1 | Synthesizer lock flag |
| cmp_i | input | 3 | Comparator levels reported in the status byte |
| supply_fail_i | input | 1 | Synthesizer supply dropout/restart pulse |
| divider_o | output | 15 | Committed divider ratio |
| cp_hi_o | output | 1 | High charge-pump current select |
| test_en_o | output | 1 | Test mode enable |
| pump_off_o | output | 1 | Charge pump disable |
| test_sel_o | output | 2 | Test function select |
| ref_div64_o | output | 1 | Reference divider 64 (1) or 128 (0) |
| tune_off_o | output | 1 | Tuning amplifier disable |
| port_o | output | 3 | General output ports |
| if_sel_o | output | 1 | IF output select |
| band_o | output | 1 | Band driver enable |

## Verification
The bench builds the block with its default parameters: a two-stage line synchronizer and the fixed 1,1,0,0,0 address prefix. It runs SCL at a quarter period of eight system clocks, so every bus edge is seen cleanly several cycles after it happens. All four strapped addresses are visited. A seeded random mix of divider pairs, control/band pairs and aborted half-pairs reaches group boundaries at stops and restarts. Reads with ACK and NACK reach the POR clear path and the SDA release path.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;

  localparam int DIV_W   = 15;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 4;

  // Bus engine states
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,     // shifting the address byte in
    ST_AACK,     // address complete, wait for SCL low to answer
    ST_AHOLD,    // address ACK driven
    ST_RX,       // shifting a write data byte in
    ST_RACKW,    // data byte complete, wait for SCL low
    ST_RACK,     // data ACK driven
    ST_TX,       // shifting the status byte out
    ST_TMACK,    // waiting for the master's ACK/NACK
    ST_TRELOAD   // master acked, next falling edge starts a new byte
  } bus_state_t;

  // Which byte the register bank expects next
  typedef enum logic [1:0] {
    GRP_ANY,
    GRP_DIV_LO,
    GRP_BAND
  } grp_t;

  // Control group, packed in the bit order of the control byte bits 6..0
  typedef struct packed {
    logic       cp_hi;
    logic       test_en;
    logic       pump_off;
    logic [1:0] test_sel;
    logic       ref_div64;
    logic       tune_off;
  } ctrl_t;

  typedef struct packed {
    logic p7;
    logic if_sel;
    logic p5;
    logic p4;
    logic p0;
  } band_t;

  localparam ctrl_t CTRL_RST = '{cp_hi: 1'b0, test_en: 1'b0, pump_off: 1'b0,
                                 test_sel: 2'b00, ref_div64: 1'b1, tune_off: 1'b1};
  localparam band_t BAND_RST = '0;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int SH_W = (STAGES < 2) ? 2 : STAGES;

  logic [SH_W-1:0] scl_sh, sda_sh;
  logic            scl_d, sda_d;
  logic            scl_s;

  // Lines idle high, so the chains reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SH_W-2:0], scl_i};
      sda_sh <= {sda_sh[SH_W-2:0], sda_i};
      scl_d  <= scl_sh[SH_W-1];
      sda_d  <= sda_sh[SH_W-1];
    end
  end

  assign scl_s     = scl_sh[SH_W-1];
  assign sda_s     = sda_sh[SH_W-1];
  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import synth_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [1:0]        hw_addr,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              sda_oe,
  output logic              rx_stb,
  output logic [BYTE_W-1:0] rx_data,
  output logic              status_sent
);

  bus_state_t        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              oe_n, rx_stb_n, sent_n;
  logic              addr_hit;

  assign addr_hit = (sh[7:1] == {ADDR_PREFIX, hw_addr});

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    sh_n     = sh;
    oe_n     = sda_oe;
    rx_stb_n = 1'b0;
    sent_n   = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: if (scl_rise) begin
          sh_n  = {sh[6:0], sda_s};
          cnt_n = cnt + 1'b1;
          if (cnt == CNT_W'(7)) st_n = ST_AACK;
        end
        ST_AACK: if (scl_fall) begin
          if (addr_hit) begin
            oe_n = 1'b1;
            st_n = ST_AHOLD;
          end else begin
            st_n = ST_IDLE;
          end
        end
        ST_AHOLD: if (scl_fall) begin
          cnt_n = '0;
          if (sh[0]) begin
            sh_n = status_byte;
            oe_n = ~status_byte[7];
            st_n = ST_TX;
          end else begin
            oe_n = 1'b0;
            st_n = ST_RX;
          end
        end
        ST_RX: if (scl_rise) begin
          sh_n  = {sh[6:0], sda_s};
          cnt_n = cnt + 1'b1;
          if (cnt == CNT_W'(7)) begin
            rx_stb_n = 1'b1;
            st_n     = ST_RACKW;
          end
        end
        ST_RACKW: if (scl_fall) begin
          oe_n = 1'b1;
          st_n = ST_RACK;
        end
        ST_RACK: if (scl_fall) begin
          oe_n  = 1'b0;
          cnt_n = '0;
          st_n  = ST_RX;
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == CNT_W'(8)) begin
              oe_n = 1'b0;
              st_n = ST_TMACK;
            end else begin
              sh_n = {sh[6:0], 1'b1};
              oe_n = ~sh[6];
            end
          end
        end
        ST_TMACK: if (scl_rise) begin
          sent_n = 1'b1;
          st_n   = sda_s ? ST_IDLE : ST_TRELOAD;
        end
        ST_TRELOAD: if (scl_fall) begin
          sh_n  = status_byte;
          oe_n  = ~status_byte[7];
          cnt_n = '0;
          st_n  = ST_TX;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      sh          <= '0;
      sda_oe      <= 1'b0;
      rx_stb      <= 1'b0;
      status_sent <= 1'b0;
    end else begin
      st          <= st_n;
      cnt         <= cnt_n;
      sh          <= sh_n;
      sda_oe      <= oe_n;
      rx_stb      <= rx_stb_n;
      status_sent <= sent_n;
    end
  end

  assign rx_data = sh;

endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import synth_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_reset,
  input  logic              rx_stb,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              status_sent,
  input  logic              supply_fail,
  input  logic              lock_flag,
  input  logic [2:0]        cmp_lvl,
  output logic [DIV_W-1:0]  divider,
  output ctrl_t             ctrl,
  output band_t             band,
  output logic              por,
  output logic [BYTE_W-1:0] status_byte
);

  localparam int HI_W = DIV_W - BYTE_W;

  grp_t             grp, grp_n;
  logic [HI_W-1:0]  hi, hi_n;
  logic [DIV_W-1:0] div_n;
  ctrl_t            ctrl_n;
  band_t            band_n;
  logic             por_n;

  always_comb begin
    grp_n  = grp;
    hi_n   = hi;
    div_n  = divider;
    ctrl_n = ctrl;
    band_n = band;
    if (frame_reset) begin
      grp_n = GRP_ANY;            // a half pair is dropped here
    end else if (rx_stb) begin
      unique case (grp)
        GRP_DIV_LO: begin
          div_n = {hi, rx_data};
          grp_n = GRP_ANY;
        end
        GRP_BAND: begin
          band_n = band_t'({rx_data[7:4], rx_data[0]});
          grp_n  = GRP_ANY;
        end
        default: begin
          if (!rx_data[7]) begin
            hi_n  = rx_data[HI_W-1:0];
            grp_n = GRP_DIV_LO;
          end else begin
            ctrl_n = ctrl_t'(rx_data[6:0]);
            grp_n  = GRP_BAND;
          end
        end
      endcase
    end
    // a dropout wins over a clear arriving in the same cycle
    if (supply_fail)      por_n = 1'b1;
    else if (status_sent) por_n = 1'b0;
    else                  por_n = por;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp     <= GRP_ANY;
      hi      <= '0;
      divider <= '0;
      ctrl    <= CTRL_RST;
      band    <= BAND_RST;
      por     <= 1'b1;
    end else begin
      grp     <= grp_n;
      hi      <= hi_n;
      divider <= div_n;
      ctrl    <= ctrl_n;
      band    <= band_n;
      por     <= por_n;
    end
  end

  // status inputs are quasi-static levels, sampled when a byte is loaded
  assign status_byte = {por, lock_flag, cmp_lvl, 3'b111};

endmodule

// File: rtl/synth_i2c_ctrl.sv
module synth_i2c_ctrl
  import synth_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b11000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       hw_addr_i,
  input  logic             lock_i,
  input  logic [2:0]       cmp_i,
  input  logic             supply_fail_i,
  output logic [DIV_W-1:0] divider_o,
  output logic             cp_hi_o,
  output logic             test_en_o,
  output logic             pump_off_o,
  output logic [1:0]       test_sel_o,
  output logic             ref_div64_o,
  output logic             tune_off_o,
  output logic [2:0]       port_o,
  output logic             if_sel_o,
  output logic             band_o
);

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              rx_stb, status_sent, por;
  logic [BYTE_W-1:0] rx_data, status_byte;
  ctrl_t             ctrl;
  band_t             band;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_byte_engine #(.ADDR_PREFIX(ADDR_PREFIX)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_s       (sda_s),
    .hw_addr     (hw_addr_i),
    .status_byte (status_byte),
    .sda_oe      (sda_oe),
    .rx_stb      (rx_stb),
    .rx_data     (rx_data),
    .status_sent (status_sent)
  );

  synth_reg_bank u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_reset (start_det | stop_det),
    .rx_stb      (rx_stb),
    .rx_data     (rx_data),
    .status_sent (status_sent),
    .supply_fail (supply_fail_i),
    .lock_flag   (lock_i),
    .cmp_lvl     (cmp_i),
    .divider     (divider_o),
    .ctrl        (ctrl),
    .band        (band),
    .por         (por),
    .status_byte (status_byte)
  );

  assign cp_hi_o     = ctrl.cp_hi;
  assign test_en_o   = ctrl.test_en;
  assign pump_off_o  = ctrl.pump_off;
  assign test_sel_o  = ctrl.test_sel;
  assign ref_div64_o = ctrl.ref_div64;
  assign tune_off_o  = ctrl.tune_off;
  assign port_o      = {band.p7, band.p5, band.p4};
  assign if_sel_o    = band.if_sel;
  assign band_o      = band.p0;

endmodule

// File: rtl/synth_i2c_ctrl_chk.sv
module synth_i2c_ctrl_chk
  import synth_i2c_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             rx_stb,
  input logic [DIV_W-1:0] divider_o,
  input logic [11:0]      cfg_word,
  input logic             por,
  input logic             status_sent
);

  // R13: SDA drive only moves on a falling SCL edge or a bus condition
  assert_oe_edge_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall | start_det | stop_det));

  // R12: a stop always leaves SDA released
  assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R4: the divider moves only right after a received byte
  assert_div_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divider_o) |-> $past(rx_stb));

  // R5 / R6: control and band outputs move only right after a received byte
  assert_cfg_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> $past(rx_stb));

  // R10: the power-on flag clears only after a status byte went out
  assert_por_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por) |-> $past(status_sent));

endmodule

bind synth_i2c_ctrl synth_i2c_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_oe      (sda_oe),
  .scl_fall    (scl_fall),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .rx_stb      (rx_stb),
  .divider_o   (divider_o),
  .cfg_word    ({cp_hi_o, test_en_o, pump_off_o, test_sel_o, ref_div64_o,
                 tune_off_o, port_o, if_sel_o, band_o}),
  .por         (por),
  .status_sent (status_sent)
);

// File: tb/synth_i2c_ctrl_test.sv
module synth_i2c_ctrl_test;

  localparam int Q = 8;  // system clocks per SCL quarter period

  logic        clk = 1'b0;
  logic        rst_n, scl, sda_m, sda_line, sda_oe, lock_i, supply_fail_i;
  logic [1:0]  hw_addr_i;
  logic [2:0]  cmp_i;
  logic [14:0] divider_o;
  logic        cp_hi_o, test_en_o, pump_off_o, ref_div64_o, tune_off_o;
  logic [1:0]  test_sel_o;
  logic [2:0]  port_o;
  logic        if_sel_o, band_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // bench model
  logic [14:0] exp_div;
  logic [6:0]  exp_ctrl;   // cp,test,pump_off,sel[1:0],div64,tune_off
  logic [4:0]  exp_band;   // p7,if_sel,p5,p4,p0
  logic [6:0]  m_hi;
  int          m_grp;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  synth_i2c_ctrl uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .hw_addr_i(hw_addr_i), .lock_i(lock_i), .cmp_i(cmp_i),
    .supply_fail_i(supply_fail_i), .divider_o(divider_o), .cp_hi_o(cp_hi_o),
    .test_en_o(test_en_o), .pump_off_o(pump_off_o), .test_sel_o(test_sel_o),
    .ref_div64_o(ref_div64_o), .tune_off_o(tune_off_o), .port_o(port_o),
    .if_sel_o(if_sel_o), .band_o(band_o)
  );

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_of(logic p, logic l, logic [2:0] c);
    return {p, l, c, 3'b111};
  endfunction

  task automatic check_regs(string req);
    chk(req, divider_o, exp_div);
    chk(req, {cp_hi_o, test_en_o, pump_off_o, test_sel_o, ref_div64_o, tune_off_o}, exp_ctrl);
    chk(req, {port_o[2], if_sel_o, port_o[1], port_o[0], band_o}, exp_band);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(2);
    m_grp = 0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    m_grp = 0;
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(2);
  endtask

  task automatic write_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl = 1'b0; tick(2);
  endtask

  task automatic read_byte(logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q);
      b = {b[6:0], sda_line};
      tick(Q); scl = 1'b0; tick(2);
    end
    sda_m = ~mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  // data byte with ack check and model update
  task automatic wr_data(logic [7:0] b, string req);
    logic ack;
    write_byte(b, ack);
    chk({req, "/R3 ack"}, ack, 1'b1);
    case (m_grp)
      1: begin exp_div = {m_hi, b}; m_grp = 0; end
      2: begin exp_band = {b[7:4], b[0]}; m_grp = 0; end
      default: if (!b[7]) begin m_hi = b[6:0]; m_grp = 1; end
               else begin exp_ctrl = b[6:0]; m_grp = 2; end
    endcase
  endtask

  task automatic open_write(string req);
    logic ack;
    bus_start();
    write_byte({5'b11000, hw_addr_i, 1'b0}, ack);
    chk(req, ack, 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    logic       ack;
    logic [7:0] rb, rb2, b;
    void'($urandom(32'd1234));
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; supply_fail_i = 1'b0;
    hw_addr_i = 2'(($urandom) & 3); lock_i = 1'b1; cmp_i = 3'b101;
    exp_div = '0; exp_ctrl = 7'b0000011; exp_band = '0; m_hi = '0; m_grp = 0;
    tick(5); rst_n = 1'b1; tick(5);

    // R11 reset state
    check_regs("R11 reset");
    chk("R11 sda_oe", sda_oe, 1'b0);

    // R9 / R10 / R2: first read sees POR set, then NACK
    lock_i = 1'($urandom); cmp_i = 3'($urandom);
    bus_start();
    write_byte({5'b11000, hw_addr_i, 1'b1}, ack);
    chk("R1/R2 read address ack", ack, 1'b1);
    read_byte(1'b0, rb);
    chk("R9/R10 status with POR", rb, status_of(1'b1, lock_i, cmp_i));
    // R12: after NACK the line stays released
    for (int i = 0; i < 2; i++) begin
      sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      chk("R12 released after NACK", sda_oe, 1'b0);
      tick(Q); scl = 1'b0; tick(2);
    end
    bus_stop();

    // R10 cleared; R12 ACK yields a second byte
    lock_i = 1'b0; cmp_i = 3'b010;
    bus_start();
    write_byte({5'b11000, hw_addr_i, 1'b1}, ack);
    read_byte(1'b1, rb);
    read_byte(1'b0, rb2);
    bus_stop();
    chk("R10 POR cleared", rb, status_of(1'b0, 1'b0, 3'b010));
    chk("R12 second byte after ACK", rb2, status_of(1'b0, 1'b0, 3'b010));
    chk("R12 stop released", sda_oe, 1'b0);

    // R10 supply dropout sets POR again
    supply_fail_i = 1'b1; tick(1); supply_fail_i = 1'b0; tick(2);
    bus_start();
    write_byte({5'b11000, hw_addr_i, 1'b1}, ack);
    read_byte(1'b0, rb);
    bus_stop();
    chk("R10 POR after supply fail", rb, status_of(1'b1, 1'b0, 3'b010));

    // R1 wrong address: no ack, data ignored
    bus_start();
    write_byte({5'b11000, hw_addr_i ^ 2'b01, 1'b0}, ack);
    chk("R1 mismatch no ack", ack, 1'b0);
    write_byte(8'h85, ack);
    chk("R1 ignored byte no ack", ack, 1'b0);
    write_byte(8'hFF, ack);
    bus_stop();
    check_regs("R1 ignored");

    // R4 divider pair commits only after second byte
    open_write("R1 write address ack");
    b = {1'b0, 7'($urandom)};
    wr_data(b, "R4");
    check_regs("R4 half pair no change");
    wr_data(8'($urandom), "R4");
    check_regs("R4 pair committed");
    // R7 sweep of pairs in the same transaction
    for (int i = 0; i < 4; i++) begin
      wr_data({1'b0, 7'($urandom)}, "R7");
      wr_data(8'($urandom), "R7");
      check_regs("R7 sweep");
    end
    // R5 control after pair, R6 band follows (MSB 0 band byte)
    wr_data(8'hD6, "R5");
    check_regs("R5 control after pair");
    wr_data(8'h5F, "R6");
    check_regs("R6 band ignores bits 3..1");
    bus_stop();

    // R8 half pair dropped at stop
    open_write("R8");
    wr_data(8'h2A, "R8");
    bus_stop();
    open_write("R8");
    wr_data(8'hA9, "R8");
    check_regs("R8 byte after stop is control");
    wr_data(8'h91, "R8");
    // R8 half pair dropped at repeated start
    wr_data(8'h11, "R8");
    open_write("R8 restart");
    wr_data(8'hF0, "R8");
    check_regs("R8 byte after restart is control");
    wr_data(8'h00, "R8");
    bus_stop();
    check_regs("R8 kept values");

    // R1 every strapped address is reachable
    for (int a = 0; a < 4; a++) begin
      hw_addr_i = 2'(a);
      open_write("R1 strap address");
      wr_data({1'b1, 7'($urandom)}, "R5");
      wr_data(8'($urandom), "R6");
      bus_stop();
      check_regs("R5/R6 per address");
    end

    // random mix of groups, with random aborted half pairs
    for (int t = 0; t < 20; t++) begin
      int ng;
      open_write("R7 random");
      ng = 1 + int'($urandom % 4);
      for (int g = 0; g < ng; g++) begin
        if ($urandom % 2 == 0) begin
          wr_data({1'b0, 7'($urandom)}, "R4");
          wr_data(8'($urandom), "R4");
        end else begin
          wr_data({1'b1, 7'($urandom)}, "R5");
          wr_data(8'($urandom), "R6");
        end
      end
      if ($urandom % 3 == 0) wr_data({1'b0, 7'($urandom)}, "R8");
      bus_stop();
      check_regs("R7/R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule